// File: doc/BRIEF.md
# IO Bank Freeze Sequencer

This block drives the five control lines of one general-purpose IO bank through an ordered, timed series of changes. It moves the bank from its operating (thawed) state to a frozen state and back again. While the bank is frozen, the pad drivers are held in safe levels, so reconfiguring pin multiplexing or buffer settings cannot send glitches to external devices. A single freeze or thaw pulse from the surrounding logic starts a whole sequence. A programmable step delay, counted in clock cycles, sets the minimum spacing between successive line changes. At 100 MHz, for example, a 20 ns spacing needs a delay of at least 2.

The block reports whether the bank is frozen or thawed and whether a sequence is in progress. A request that would not change the state completes at once and leaves every line untouched. A request that arrives while a sequence is running is dropped.

Top module: `io_freeze_seq`

## Requirements
- R1: While reset is low at a clock edge, the next cycle shows all five control lines low, `thawed` = 0 and `busy` = 0 (frozen).
- R2: The control word {slew_n, pullup_n, tristate_n, bushold_n, cfg_done} (bits 4..0) is 5'b00000 when frozen and idle and 5'b11111 when thawed and idle.
- R3: A freeze pulse accepted at edge N while thawed and idle drives slew_n, pullup_n and tristate_n low together after edge N, leaves bushold_n and cfg_done high, and raises `busy`.
- R4: With D = max(step_dly, 1), the freeze sequence drives bushold_n and cfg_done low together at edge N+D. At that same edge `busy` falls and `thawed` becomes 0.
- R5: A thaw pulse accepted at edge N while frozen and idle changes the lines in three steps. At edge N, bushold_n and cfg_done go high. At edge N+D, pullup_n and tristate_n go high. At edge N+2D, slew_n goes high, and at that edge `busy` falls and `thawed` becomes 1.
- R6: `thawed` keeps its starting value for the whole sequence and changes only at the edge of the final step.
- R7: Two successive line changes within one sequence are at least D cycles apart.
- R8: A freeze pulse while frozen and idle, or a thaw pulse while thawed and idle, changes no line and does not raise `busy`.
- R9: Freeze and thaw pulses that arrive while `busy` is high have no effect on the running sequence or on the state that follows it.
- R10: When freeze and thaw pulses arrive together while idle, freeze wins. If the bank is thawed, it freezes. If it is frozen, nothing happens.
- R11: step_dly is sampled when a sequence starts. Changing it while `busy` is high does not change that sequence's timing.
- R12: At all times slew_n implies tristate_n, and tristate_n implies cfg_done. In addition, pullup_n always equals tristate_n and bushold_n always equals cfg_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frz_req | input | 1 | Freeze request pulse |
| thw_req | input | 1 | Thaw request pulse |
| step_dly | input | DLY_W | Minimum cycles between steps (0 treated as 1) |
| slew_n | output | 1 | Slew enable, active low |
| pullup_n | output | 1 | Weak pull-up enable, active low |
| tristate_n | output | 1 | Tristate enable, active low |
| bushold_n | output | 1 | Bus-hold enable, active low |
| cfg_done | output | 1 | Configuration done, active high |
| thawed | output | 1 | Status: 0 frozen, 1 thawed |
| busy | output | 1 | A sequence is in progress |

## Verification
The minimum-gap property assumes that step_dly holds the value the block captured when the sequence started. The checker therefore latches its own copy of step_dly whenever the block is idle and sees a request, which lets the bench change the input freely while `busy` is high. The no-effect properties assume that request pulses last one cycle while the block is idle. The bench raises each idle request for exactly one edge and only holds requests high across several edges while a sequence is already running. It sweeps every step delay from 0 to 5, with and without disturbing requests, so both the degenerate single-cycle gap and longer gaps are covered.

// File: rtl/iofrz_pkg.sv
// Shared definitions for the IO bank freeze sequencer.
// Assumes a five-line control word with the bit order listed below.
package iofrz_pkg;

    localparam int CTL_W    = 5;
    localparam int BIT_CFG  = 0;
    localparam int BIT_HOLD = 1;
    localparam int BIT_TRI  = 2;
    localparam int BIT_PULL = 3;
    localparam int BIT_SLEW = 4;

    localparam logic [CTL_W-1:0] CTL_FROZEN = '0;
    localparam logic [CTL_W-1:0] CTL_THAWED = '1;

    typedef enum logic [2:0] {
        SQ_FROZEN,
        SQ_FRZ_WAIT,
        SQ_THAWED,
        SQ_THW_WAIT1,
        SQ_THW_WAIT2
    } sq_state_t;

    typedef enum logic [2:0] {
        STEP_NONE,
        STEP_FRZ_OUTER,
        STEP_FRZ_INNER,
        STEP_THW_INNER,
        STEP_THW_PULL,
        STEP_THW_SLEW
    } step_t;

    // Lines pulled to their frozen level by a step.
    function automatic logic [CTL_W-1:0] step_clr_mask(step_t s);
        logic [CTL_W-1:0] m;
        m = '0;
        case (s)
            STEP_FRZ_OUTER: begin
                m[BIT_SLEW] = 1'b1;
                m[BIT_PULL] = 1'b1;
                m[BIT_TRI]  = 1'b1;
            end
            STEP_FRZ_INNER: begin
                m[BIT_HOLD] = 1'b1;
                m[BIT_CFG]  = 1'b1;
            end
            default: m = '0;
        endcase
        return m;
    endfunction

    // Lines released to their operating level by a step.
    function automatic logic [CTL_W-1:0] step_set_mask(step_t s);
        logic [CTL_W-1:0] m;
        m = '0;
        case (s)
            STEP_THW_INNER: begin
                m[BIT_HOLD] = 1'b1;
                m[BIT_CFG]  = 1'b1;
            end
            STEP_THW_PULL: begin
                m[BIT_PULL] = 1'b1;
                m[BIT_TRI]  = 1'b1;
            end
            STEP_THW_SLEW: m[BIT_SLEW] = 1'b1;
            default:       m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/iofrz_step_timer.sv
// Step spacing timer.
// It captures the step delay when a sequence starts and then counts the
// wait between steps. A delay of zero is treated as one cycle.
// Assumes that start and reload are never both high.
module iofrz_step_timer #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             reload,
    input  logic [DLY_W-1:0] dly_in,
    output logic             expired
);
    localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

    logic [DLY_W-1:0] dly_q;
    logic [DLY_W-1:0] cnt_q;
    logic [DLY_W-1:0] dly_sel;
    logic [DLY_W-1:0] load_val;

    // Pick the fresh delay at the start of a sequence, the held one otherwise.
    always_comb begin
        dly_sel  = start ? dly_in : dly_q;
        load_val = (dly_sel == '0) ? '0 : dly_sel - ONE;
    end

    // Hold the delay for the duration of the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)     dly_q <= '0;
        else if (start) dly_q <= dly_in;
    end

    // Count down the remaining wait cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (start || reload)  cnt_q <= load_val;
        else if (cnt_q != '0)      cnt_q <= cnt_q - ONE;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/iofrz_seq_fsm.sv
// Sequencing state machine.
// It accepts requests only while idle, with freeze taking priority over
// thaw, and it issues one step code at each edge where a line group
// changes. It assumes that the timer reports expiry D cycles after each
// load.
module iofrz_seq_fsm
    import iofrz_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  frz_req,
    input  logic  thw_req,
    input  logic  expired,
    output logic  start,
    output logic  reload,
    output step_t step,
    output logic  busy,
    output logic  thawed
);
    sq_state_t state_q, state_d;

    // Decide the next state and the step applied at this edge.
    always_comb begin
        state_d = state_q;
        step    = STEP_NONE;
        start   = 1'b0;
        reload  = 1'b0;
        case (state_q)
            SQ_FROZEN: begin
                if (!frz_req && thw_req) begin
                    step    = STEP_THW_INNER;
                    start   = 1'b1;
                    state_d = SQ_THW_WAIT1;
                end
            end
            SQ_THAWED: begin
                if (frz_req) begin
                    step    = STEP_FRZ_OUTER;
                    start   = 1'b1;
                    state_d = SQ_FRZ_WAIT;
                end
            end
            SQ_FRZ_WAIT: begin
                if (expired) begin
                    step    = STEP_FRZ_INNER;
                    state_d = SQ_FROZEN;
                end
            end
            SQ_THW_WAIT1: begin
                if (expired) begin
                    step    = STEP_THW_PULL;
                    reload  = 1'b1;
                    state_d = SQ_THW_WAIT2;
                end
            end
            SQ_THW_WAIT2: begin
                if (expired) begin
                    step    = STEP_THW_SLEW;
                    state_d = SQ_THAWED;
                end
            end
            default: state_d = SQ_FROZEN;
        endcase
    end

    // State register; reset lands in the frozen state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_FROZEN;
        else        state_q <= state_d;
    end

    // Status reflects the starting state until the final step lands.
    always_comb begin
        busy   = (state_q == SQ_FRZ_WAIT) || (state_q == SQ_THW_WAIT1) ||
                 (state_q == SQ_THW_WAIT2);
        thawed = (state_q == SQ_THAWED) || (state_q == SQ_FRZ_WAIT);
    end

endmodule

// File: rtl/iofrz_ctl_drive.sv
// Control line register bank.
// Each line is registered on its own and moves only when the current
// step names it in its clear or set mask. It assumes that no step
// both clears and sets the same line.
module iofrz_ctl_drive
    import iofrz_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  step_t            step,
    output logic [CTL_W-1:0] ctl
);
    logic [CTL_W-1:0] clr_m;
    logic [CTL_W-1:0] set_m;

    // Expand the step code into per-line masks.
    always_comb begin
        clr_m = step_clr_mask(step);
        set_m = step_set_mask(step);
    end

    for (genvar b = 0; b < CTL_W; b++) begin : g_line
        // One flop per line, reset to its frozen level.
        always_ff @(posedge clk) begin
            if (!rst_n)        ctl[b] <= CTL_FROZEN[b];
            else if (clr_m[b]) ctl[b] <= 1'b0;
            else if (set_m[b]) ctl[b] <= 1'b1;
        end
    end

endmodule

// File: rtl/io_freeze_seq.sv
// IO bank freeze sequencer, top level.
// It joins the state machine, the step timer and the line registers.
// It assumes that requests are single-cycle pulses, synchronous to clk.
module io_freeze_seq
    import iofrz_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frz_req,
    input  logic             thw_req,
    input  logic [DLY_W-1:0] step_dly,
    output logic             slew_n,
    output logic             pullup_n,
    output logic             tristate_n,
    output logic             bushold_n,
    output logic             cfg_done,
    output logic             thawed,
    output logic             busy
);
    logic             start;
    logic             reload;
    logic             expired;
    step_t            step;
    logic [CTL_W-1:0] ctl;

    iofrz_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .frz_req (frz_req),
        .thw_req (thw_req),
        .expired (expired),
        .start   (start),
        .reload  (reload),
        .step    (step),
        .busy    (busy),
        .thawed  (thawed)
    );

    iofrz_step_timer #(.DLY_W(DLY_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .reload  (reload),
        .dly_in  (step_dly),
        .expired (expired)
    );

    iofrz_ctl_drive u_drive (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .ctl   (ctl)
    );

    assign slew_n     = ctl[BIT_SLEW];
    assign pullup_n   = ctl[BIT_PULL];
    assign tristate_n = ctl[BIT_TRI];
    assign bushold_n  = ctl[BIT_HOLD];
    assign cfg_done   = ctl[BIT_CFG];

endmodule

// File: rtl/io_freeze_seq_chk.sv
// Property checker for io_freeze_seq, attached with bind.
// It assumes that requests made while idle are single-cycle pulses.
module io_freeze_seq_chk #(
    parameter int DLY_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frz_req,
    input logic             thw_req,
    input logic [DLY_W-1:0] step_dly,
    input logic             slew_n,
    input logic             pullup_n,
    input logic             tristate_n,
    input logic             bushold_n,
    input logic             cfg_done,
    input logic             thawed,
    input logic             busy
);
    logic [4:0]       word;
    logic [4:0]       word_q;
    logic [DLY_W-1:0] dly_cap;
    logic [DLY_W:0]   gap_cnt;
    logic [DLY_W:0]   need;

    assign word = {slew_n, pullup_n, tristate_n, bushold_n, cfg_done};
    assign need = (dly_cap == '0) ? (DLY_W+1)'(1) : {1'b0, dly_cap};

    // Track the previous word, the delay in force and cycles since a change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            dly_cap <= '0;
            gap_cnt <= '1;
        end else begin
            word_q <= word;
            if (!busy && (frz_req || thw_req)) dly_cap <= step_dly;
            if (word != word_q)        gap_cnt <= (DLY_W+1)'(1);
            else if (gap_cnt != '1)    gap_cnt <= gap_cnt + 1'b1;
        end
    end

    a_r1_reset_frozen: assert property (@(posedge clk)
        !rst_n |=> (word == 5'b00000 && !thawed && !busy));

    a_r2_idle_word: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (word == (thawed ? 5'b11111 : 5'b00000)));

    a_r12_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (!slew_n || tristate_n) && (!tristate_n || cfg_done));

    a_r12_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        (pullup_n == tristate_n) && (bushold_n == cfg_done));

    a_r7_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ((word != word_q) && $past(busy)) |-> (gap_cnt >= need));

    a_r6_status_steady: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(thawed)));

    a_r8_noop_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !thawed && frz_req) |=> (!busy && !thawed && word == 5'b00000));

    a_r8_noop_thawed: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && thawed && thw_req && !frz_req) |=> (!busy && thawed && word == 5'b11111));

endmodule

bind io_freeze_seq io_freeze_seq_chk #(.DLY_W(DLY_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frz_req    (frz_req),
    .thw_req    (thw_req),
    .step_dly   (step_dly),
    .slew_n     (slew_n),
    .pullup_n   (pullup_n),
    .tristate_n (tristate_n),
    .bushold_n  (bushold_n),
    .cfg_done   (cfg_done),
    .thawed     (thawed),
    .busy       (busy)
);

// File: tb/test_io_freeze_seq.sv
module test_io_freeze_seq;
    localparam int DLY_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frz_req = 1'b0;
    logic             thw_req = 1'b0;
    logic [DLY_W-1:0] step_dly = '0;
    logic slew_n, pullup_n, tristate_n, bushold_n, cfg_done, thawed, busy;
    wire  [4:0] ctl = {slew_n, pullup_n, tristate_n, bushold_n, cfg_done};

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    io_freeze_seq #(.DLY_W(DLY_W)) i_io_freeze_seq (
        .clk(clk), .rst_n(rst_n), .frz_req(frz_req), .thw_req(thw_req),
        .step_dly(step_dly), .slew_n(slew_n), .pullup_n(pullup_n),
        .tristate_n(tristate_n), .bushold_n(bushold_n), .cfg_done(cfg_done),
        .thawed(thawed), .busy(busy)
    );

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string tag, logic [4:0] e_ctl, logic e_busy, logic e_th);
        checks++;
        if (ctl !== e_ctl || busy !== e_busy || thawed !== e_th) begin
            errors++;
            $display("FAIL %s: ctl=%b busy=%b thawed=%b expected ctl=%b busy=%b thawed=%b",
                     tag, ctl, busy, thawed, e_ctl, e_busy, e_th);
        end
    endtask

    // R5 thaw from frozen; with disturb, R9 and R11 stress during busy.
    task automatic run_thaw(int dly, bit disturb);
        int d = (dly == 0) ? 1 : dly;
        string tag = disturb ? "R9 R11 R5 thaw under requests" : "R5 R6 R12 thaw step";
        step_dly = DLY_W'(dly);
        thw_req  = 1'b1;
        tick();
        thw_req  = 1'b0;
        for (int k = 0; k <= 2*d + 1; k++) begin
            if (k < d)          check(tag, 5'b00011, 1'b1, 1'b0);
            else if (k < 2*d)   check(tag, 5'b01111, 1'b1, 1'b0);
            else                check(tag, 5'b11111, 1'b0, 1'b1);
            if (disturb && (k + 1 <= 2*d - 1)) begin
                frz_req  = 1'b1;
                thw_req  = 1'b1;
                step_dly = '1;
            end else begin
                frz_req  = 1'b0;
                thw_req  = 1'b0;
            end
            tick();
        end
        step_dly = DLY_W'(dly);
    endtask

    // R3 R4 freeze from thawed; with both pulses set, R10.
    task automatic run_freeze(int dly, bit both);
        int d = (dly == 0) ? 1 : dly;
        string tag = both ? "R10 freeze wins" : "R3 R4 R7 freeze step";
        step_dly = DLY_W'(dly);
        frz_req  = 1'b1;
        thw_req  = both;
        tick();
        frz_req  = 1'b0;
        thw_req  = 1'b0;
        for (int k = 0; k <= d + 1; k++) begin
            if (k < d) check(tag, 5'b00011, 1'b1, 1'b1);
            else       check(tag, 5'b00000, 1'b0, 1'b0);
            tick();
        end
    endtask

    // R8 / R10 request that should do nothing.
    task automatic run_noop(string tag, bit f, bit t, logic [4:0] e_ctl, logic e_th);
        frz_req = f;
        thw_req = t;
        tick();
        frz_req = 1'b0;
        thw_req = 1'b0;
        check(tag, e_ctl, 1'b0, e_th);
        tick();
        check(tag, e_ctl, 1'b0, e_th);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick();
        tick();
        check("R1 reset held", 5'b00000, 1'b0, 1'b0);
        rst_n = 1'b1;
        tick();
        check("R1 R2 after reset", 5'b00000, 1'b0, 1'b0);
        run_noop("R8 freeze while frozen", 1'b1, 1'b0, 5'b00000, 1'b0);
        run_noop("R10 both while frozen", 1'b1, 1'b1, 5'b00000, 1'b0);
        for (int dly = 0; dly <= 5; dly++) begin
            run_thaw(dly, (dly % 2) == 1);
            run_noop("R8 thaw while thawed", 1'b0, 1'b1, 5'b11111, 1'b1);
            run_freeze(dly, dly == 3);
        end
        // Mid-sequence reset returns to the frozen word (R1).
        run_thaw(3, 1'b0);
        step_dly = DLY_W'(4);
        frz_req  = 1'b1;
        tick();
        frz_req  = 1'b0;
        rst_n    = 1'b0;
        tick();
        check("R1 reset mid sequence", 5'b00000, 1'b0, 1'b0);
        rst_n = 1'b1;
        tick();
        check("R1 R2 idle after reset", 5'b00000, 1'b0, 1'b0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule